// File: doc/BRIEF.md
# Modal Divide-by-N Pulse Counter

This block divides a single clock by a programmable count N. Every N clock cycles it raises `pulse_o`. N comes from a 16-bit jam word made of four 4-bit digits. A 3-bit mode select sets the modulus M of the first counting section (2, 4, 5, 8 or 10). M also decides how the lowest jam digit is split between the first-section preset and the value of the most significant section. The three upper jam digits are BCD tens-style decades in the middle of the chain. In every counting mode:

N = M × (1000·top + 100·jam[15:12] + 10·jam[11:8] + jam[7:4]) + first

Here `first` is taken from the low `b` bits of `jam[3:0]` and `top` from the remaining upper bits of that digit. The next count is loaded from the jam word at the cycle in which a pulse is produced.

Further encodings of the mode select give other behaviour:
- An initialise (parked) mode holds the counter ready to start.
- A fixed divide-by-10 000 mode ignores the jam word.
- A hold input can keep the output high after a pulse until it is released.

A single clock and a synchronous active-high reset are used, and the output is registered.

Top module: `modal_divider`

## Requirements
- R1: With `mode_sel` = {a,b,c}, the first-section modulus M and the preset width b are: 3'b111 gives M=2, b=1; 3'b011 gives M=4, b=2; 3'b101 gives M=5, b=3; 3'b001 gives M=8, b=3; 3'b110 gives M=10, b=4. In each of these modes `pulse_o` rises once every N cycles, where N follows the formula above.
- R2: `first` = `jam[3:0]` mod 2^b and `top` = `jam[3:0]` >> b. Each upper top value weighs M·1000 cycles, `jam[15:12]` weighs M·100, `jam[11:8]` weighs M·10 and `jam[7:4]` weighs M.
- R3: If any of `jam[15:4]`'s digits is above 9, or `first` ≥ M, or the formula gives 0, the count becomes the mode maximum M·1000·(16 >> b) − 1. That is 15 999 for M = 2, 4 or 8, and 9 999 for M = 5 or 10. The counter never holds a value above 15 999.
- R4: With `mode_sel` = 3'b010 and `hold_en` low, the period is fixed at 10 000 cycles whatever `jam` holds.
- R5: With `mode_sel` = 3'b010 and `hold_en` high, the block divides as mode M=10 (b=4) using `jam`, and each pulse is one cycle wide despite `hold_en`.
- R6: Whenever `mode_sel[1:0]` = 2'b00, the counter is parked. Apart from a pulse already due (R7), no pulse is produced. After leaving this mode, the first pulse comes exactly N cycles later.
- R7: If the parked mode is entered when the next pulse is due in one or two cycles, that pulse still appears in its scheduled cycle.
- R8: With `hold_en` low, and N ≥ 2, each pulse lasts one cycle. A new count is loaded at each pulse, so pulses repeat every N cycles.
- R9: With `hold_en` high in any mode other than 3'b010, `pulse_o` stays high from a pulse onward until the first clock edge at which `hold_en` is low.
- R10: While `rst` is high, `pulse_o` is low and the counter is parked. After release in a counting mode, the first pulse comes N cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Mode select {a,b,c} |
| hold_en | input | 1 | Output hold (latch) enable |
| jam | input | 16 | Four 4-bit count digits |
| pulse_o | output | 1 | Registered divided output |

## Verification
The bench builds the block with its defaults: four 4-bit digits and a 14-bit counter. This lets it drive every legal first-section preset in every mode, combined with several small middle-decade values, so each period stays short enough to be measured twice. The same configuration also reaches the full-length cases at the normal bench length: the 9 999 and 15 999 fallbacks, the fixed 10 000 divisor, and the top-section weights. Parked-mode entry is placed one, two and three cycles before a pulse, to expose the boundary of the on-time rule.

// File: rtl/divn_pkg.sv
package divn_pkg;

    typedef enum logic [2:0] {
        OP_PRESET,
        OP_DIV2,
        OP_DIV4,
        OP_DIV5,
        OP_DIV8,
        OP_DIV10,
        OP_FIXED
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [3:0] modulus;   // first-section modulus M
        logic [2:0] low_bits;  // bits of the low digit used as first-section preset
        logic       hold_ok;   // output hold may act in this mode
    } mode_cfg_t;

    function automatic int unsigned pow10(input int unsigned n);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < n; i++) begin
            r = r * 10;
        end
        return r;
    endfunction

    function automatic mode_cfg_t decode_mode(input logic [2:0] sel, input logic hold);
        mode_cfg_t c;
        c.op       = OP_PRESET;
        c.modulus  = 4'd0;
        c.low_bits = 3'd0;
        c.hold_ok  = 1'b1;
        if (sel[1:0] != 2'b00) begin
            case (sel)
                3'b111: begin c.op = OP_DIV2;  c.modulus = 4'd2;  c.low_bits = 3'd1; end
                3'b011: begin c.op = OP_DIV4;  c.modulus = 4'd4;  c.low_bits = 3'd2; end
                3'b101: begin c.op = OP_DIV5;  c.modulus = 4'd5;  c.low_bits = 3'd3; end
                3'b001: begin c.op = OP_DIV8;  c.modulus = 4'd8;  c.low_bits = 3'd3; end
                3'b110: begin c.op = OP_DIV10; c.modulus = 4'd10; c.low_bits = 3'd4; end
                3'b010: begin
                    c.modulus  = 4'd10;
                    c.low_bits = 3'd4;
                    if (hold) begin
                        c.op      = OP_DIV10;
                        c.hold_ok = 1'b0;
                    end else begin
                        c.op      = OP_FIXED;
                    end
                end
                default: c.op = OP_PRESET;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/divn_divisor.sv
module divn_divisor
    import divn_pkg::*;
#(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 4,
    parameter int CNT_W      = 14
) (
    input  logic [2:0]                     mode_sel,
    input  logic                           hold_en,
    input  logic [DIGIT_W*NUM_DIGITS-1:0]  jam,
    output logic                           preset,
    output logic                           hold_ok,
    output logic [CNT_W-1:0]               divisor
);

    localparam int          MID       = NUM_DIGITS - 1;
    localparam int unsigned TOP_W     = pow10(MID);
    localparam int unsigned FIXED_DIV = pow10(NUM_DIGITS);

    mode_cfg_t             cfg;
    logic [MID-1:0]        mid_ok;
    logic [MID-1:0][31:0]  mid_term;

    assign cfg = decode_mode(mode_sel, hold_en);

    // middle decades: validity and weighted value per digit
    generate
        for (genvar g = 0; g < MID; g++) begin : g_mid
            logic [DIGIT_W-1:0] dig;
            assign dig         = jam[(g+1)*DIGIT_W +: DIGIT_W];
            assign mid_ok[g]   = (dig <= DIGIT_W'(9));
            assign mid_term[g] = 32'(dig) * pow10(g);
        end
    endgenerate

    logic [DIGIT_W-1:0] low_dig;
    logic [DIGIT_W-1:0] first_val;
    logic [DIGIT_W-1:0] top_val;
    int unsigned        mid_sum;
    int unsigned        mod_u;
    int unsigned        raw;
    int unsigned        top_max;
    logic               bad;

    always_comb begin
        low_dig   = jam[DIGIT_W-1:0];
        first_val = low_dig & DIGIT_W'((32'(1) << cfg.low_bits) - 32'(1));
        top_val   = low_dig >> cfg.low_bits;
        mid_sum   = 0;
        for (int i = 0; i < MID; i++) begin
            mid_sum = mid_sum + mid_term[i];
        end
        mod_u   = 32'(cfg.modulus);
        raw     = mod_u * (TOP_W * 32'(top_val) + mid_sum) + 32'(first_val);
        top_max = mod_u * TOP_W * ((32'(1) << DIGIT_W) >> cfg.low_bits) - 32'(1);
        bad     = !(&mid_ok) || (32'(first_val) >= mod_u) || (raw == 0);
        case (cfg.op)
            OP_PRESET: divisor = '0;
            OP_FIXED:  divisor = CNT_W'(FIXED_DIV);
            default:   divisor = bad ? CNT_W'(top_max) : CNT_W'(raw);
        endcase
    end

    assign preset  = (cfg.op == OP_PRESET);
    assign hold_ok = cfg.hold_ok;

endmodule

// File: rtl/divn_core.sv
module divn_core #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preset,
    input  logic [CNT_W-1:0] divisor,
    output logic [CNT_W-1:0] rem,
    output logic             fire
);

    // rem = cycles left until the next pulse; 0 means parked / fresh start
    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] rem_n;
    logic             park;

    always_comb begin
        eff  = (rem == '0) ? divisor : rem;
        park = preset && ((rem == '0) || (rem > CNT_W'(2)));
        fire = !park && (eff == CNT_W'(1));
        if (park) begin
            rem_n = '0;
        end else if (fire) begin
            rem_n = preset ? '0 : divisor;
        end else begin
            rem_n = eff - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else begin
            rem <= rem_n;
        end
    end

endmodule

// File: rtl/divn_out.sv
module divn_out (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic hold_en,
    input  logic hold_ok,
    output logic pulse_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire | (pulse_q & hold_en & hold_ok);
        end
    end

endmodule

// File: rtl/modal_divider.sv
module modal_divider #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 4,
    parameter int CNT_W      = 14
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [2:0]                    mode_sel,
    input  logic                          hold_en,
    input  logic [DIGIT_W*NUM_DIGITS-1:0] jam,
    output logic                          pulse_o
);

    logic             preset;
    logic             hold_ok;
    logic [CNT_W-1:0] divisor;
    logic [CNT_W-1:0] rem;
    logic             fire;

    divn_divisor #(
        .DIGIT_W    (DIGIT_W),
        .NUM_DIGITS (NUM_DIGITS),
        .CNT_W      (CNT_W)
    ) i_divisor (
        .mode_sel (mode_sel),
        .hold_en  (hold_en),
        .jam      (jam),
        .preset   (preset),
        .hold_ok  (hold_ok),
        .divisor  (divisor)
    );

    divn_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk     (clk),
        .rst     (rst),
        .preset  (preset),
        .divisor (divisor),
        .rem     (rem),
        .fire    (fire)
    );

    divn_out i_out (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .hold_en (hold_en),
        .hold_ok (hold_ok),
        .pulse_q (pulse_o)
    );

endmodule

// File: rtl/modal_divider_chk.sv
module modal_divider_chk
    import divn_pkg::*;
#(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 4,
    parameter int CNT_W      = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             preset,
    input logic             hold_en,
    input logic             hold_ok,
    input logic [CNT_W-1:0] rem,
    input logic             pulse_o
);

    localparam int unsigned RANGE_MAX = (32'(1) << DIGIT_W) * pow10(NUM_DIGITS - 1) - 32'(1);
    localparam int unsigned FIX_MAX   = pow10(NUM_DIGITS);
    localparam int unsigned LIMIT     = (RANGE_MAX > FIX_MAX) ? RANGE_MAX : FIX_MAX;

    // R8
    last_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rem == CNT_W'(1) |=> pulse_o);

    // R7
    due_in_two_chk: assert property (@(posedge clk) disable iff (rst)
        rem == CNT_W'(2) |=> ##1 pulse_o);

    // R6
    park_clear_chk: assert property (@(posedge clk) disable iff (rst)
        preset && (rem > CNT_W'(2)) |=> rem == '0);

    // R6
    park_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        preset && $past(preset) && $past(preset, 2) && !hold_en |=> !pulse_o);

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o && hold_en && hold_ok |=> pulse_o);

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(rem) <= LIMIT);

endmodule

bind modal_divider modal_divider_chk #(
    .DIGIT_W    (DIGIT_W),
    .NUM_DIGITS (NUM_DIGITS),
    .CNT_W      (CNT_W)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .preset  (preset),
    .hold_en (hold_en),
    .hold_ok (hold_ok),
    .rem     (rem),
    .pulse_o (pulse_o)
);

// File: tb/test_modal_divider.sv
module test_modal_divider;

    localparam int CLK_PERIOD = 10;

    logic        clk      = 1'b0;
    logic        rst      = 1'b1;
    logic [2:0]  mode_sel = 3'b000;
    logic        hold_en  = 1'b0;
    logic [15:0] jam      = '0;
    logic        pulse_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modal_divider i_modal_divider (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .hold_en  (hold_en),
        .jam      (jam),
        .pulse_o  (pulse_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected divisor computed from the requirements (R1-style formula)
    function automatic int exp_div(input bit [2:0] sel, input bit le, input bit [15:0] j);
        int m, b, low, first, top, n, mx;
        bit bcd_ok;
        if (sel[1:0] == 2'b00) return 0;
        if (sel == 3'b010 && !le) return 10000;
        case (sel)
            3'b111:  begin m = 2;  b = 1; end
            3'b011:  begin m = 4;  b = 2; end
            3'b101:  begin m = 5;  b = 3; end
            3'b001:  begin m = 8;  b = 3; end
            default: begin m = 10; b = 4; end
        endcase
        low    = int'(j[3:0]);
        first  = low % (1 << b);
        top    = low / (1 << b);
        bcd_ok = (j[7:4] < 10) && (j[11:8] < 10) && (j[15:12] < 10);
        n  = m * (1000*top + 100*int'(j[15:12]) + 10*int'(j[11:8]) + int'(j[7:4])) + first;
        mx = m * 1000 * (16 / (1 << b)) - 1;
        if (!bcd_ok || first >= m || n == 0) return mx;
        return n;
    endfunction

    task automatic wait_pulse(output int c, input int limit);
        c = 0;
        forever begin
            @(negedge clk);
            c++;
            if (pulse_o || c >= limit) break;
        end
    endtask

    task automatic park();
        @(negedge clk);
        mode_sel = 3'b000;
        hold_en  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_case(input bit [2:0] sel, input bit le, input bit [15:0] j,
                            input string tag, input bit twice);
        int n;
        int c;
        n = exp_div(sel, le, j);
        park();
        mode_sel = sel;
        hold_en  = le;
        jam      = j;
        wait_pulse(c, n + 8);
        check(c == n, {tag, " first period"}, c, n);
        if (twice && n >= 2) begin
            @(negedge clk);
            check(!pulse_o, {tag, " one-cycle width"}, int'(pulse_o), 0);
            wait_pulse(c, n + 8);
            check(c + 1 == n, {tag, " repeat period"}, c + 1, n);
        end
    endtask

    task automatic preset_entry(input int lead, input bit expect_pulse, input string tag);
        int c;
        int seen;
        park();
        mode_sel = 3'b111;
        jam      = 16'h0100;   // M=2, middle tens digit 1 -> N=20
        wait_pulse(c, 40);
        check(c == 20, "R6 first pulse after leaving parked mode", c, 20);
        repeat (20 - lead) @(negedge clk);
        mode_sel = 3'b000;
        seen = -1;
        for (int k = 20 - lead + 1; k <= 30; k++) begin
            @(negedge clk);
            if (pulse_o && seen < 0) seen = k;
        end
        check(seen == (expect_pulse ? 20 : -1), tag, seen, expect_pulse ? 20 : -1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        bit [2:0] sels [5] = '{3'b111, 3'b011, 3'b101, 3'b001, 3'b110};
        int       mods [5] = '{2, 4, 5, 8, 10};
        int       d2s  [3] = '{1, 3, 9};
        int       d3s  [2] = '{0, 2};
        int       c;
        bit       hi;

        // R10: reset holds output low, first pulse N cycles after release
        mode_sel = 3'b111;
        jam      = 16'h0021;   // M=2: first=1, units=2 -> N=5
        repeat (3) @(negedge clk);
        check(!pulse_o, "R10 output low in reset", int'(pulse_o), 0);
        rst = 1'b0;
        wait_pulse(c, 20);
        check(c == 5, "R10 first pulse after reset", c, 5);

        // R1 / R8: every first-section preset in every mode, small middle decades
        for (int mi = 0; mi < 5; mi++) begin
            for (int f = 0; f < mods[mi]; f++) begin
                for (int a = 0; a < 3; a++) begin
                    for (int t = 0; t < 2; t++) begin
                        run_case(sels[mi], 1'b0,
                                 {4'd0, 4'(d3s[t]), 4'(d2s[a]), 4'(f)},
                                 "R1 R8 mode sweep", 1'b1);
                    end
                end
            end
        end

        // R5: fixed-divisor encoding with hold high divides by ten, no latching
        run_case(3'b010, 1'b1, 16'h0023, "R5 divide-by-ten without hold", 1'b1);

        // R2: split of the low digit and weight of upper digits
        run_case(3'b111, 1'b0, 16'h0023, "R2 top section in mode 2", 1'b0);
        run_case(3'b001, 1'b0, 16'h000D, "R2 top section in mode 8", 1'b0);
        run_case(3'b011, 1'b0, 16'h1002, "R2 hundreds digit in mode 4", 1'b0);

        // R3: fallback to the mode maximum
        run_case(3'b101, 1'b0, 16'h0016, "R3 first preset not below modulus", 1'b0);
        run_case(3'b111, 1'b0, 16'h0000, "R3 zero divisor", 1'b0);
        run_case(3'b110, 1'b0, 16'h0B01, "R3 invalid BCD digit", 1'b0);

        // R4: fixed 10000 regardless of jam
        run_case(3'b010, 1'b0, 16'h1234, "R4 fixed divisor", 1'b0);
        run_case(3'b010, 1'b0, 16'hFFFF, "R4 jam ignored", 1'b0);

        // R9: output hold
        park();
        mode_sel = 3'b011;
        hold_en  = 1'b1;
        jam      = 16'h0011;   // M=4: first=1, units=1 -> N=5
        wait_pulse(c, 20);
        check(c == 5, "R9 first pulse with hold", c, 5);
        hi = 1'b1;
        repeat (7) begin
            @(negedge clk);
            if (!pulse_o) hi = 1'b0;
        end
        check(hi, "R9 output held high", int'(hi), 1);
        hold_en = 1'b0;
        @(negedge clk);
        check(!pulse_o, "R9 output drops when hold released", int'(pulse_o), 0);
        wait_pulse(c, 10);
        check(c == 2, "R8 pulse schedule unchanged by hold", c, 2);
        @(negedge clk);
        check(!pulse_o, "R8 one-cycle width after hold released", int'(pulse_o), 0);

        // R7 / R6: parked mode entered just before a pulse
        preset_entry(1, 1'b1, "R7 pulse on time, preset one cycle before");
        preset_entry(2, 1'b1, "R7 pulse on time, preset two cycles before");
        preset_entry(3, 1'b0, "R6 no pulse, preset three cycles before");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule